// File: doc/BRIEF.md
# Asynchronous receive buffer with error flags

This block is the back end of an asynchronous serial receiver. A shift register in front of it presents each completed character as a one-cycle strobe, together with the data bits, the sampled parity bit and up to two sampled stop bits. The block moves the character into a 16-bit receive buffer word. At that same moment it judges the character for framing, parity and overrun errors.

The host reads the buffer word at any time. A separate strobe marks a read of its low byte, and that read acknowledges the character and clears the error flags. The flags also clear while reception is disabled or the serial interface is switched off. In the clock-synchronous and two-wire bus modes, the error flags are meaningless and read as 0. A summary flag shows whether any individual error is present.

Mode codes on `mode`:

| Code | Meaning | Data width |
|------|---------|------------|
| 000 | Interface off | — |
| 001 | Clock-synchronous | 8 |
| 010 | Two-wire bus | 9 |
| 011 | Reserved | 8 |
| 100 | Asynchronous | 7 |
| 101 | Asynchronous | 8 |
| 110 | Asynchronous | 9 |
| 111 | Asynchronous | 8 |

Top module: `uart_rx_errbuf`

## Requirements
- R1: On a character strobe while enabled (`rx_en`=1, `mode`≠000), the buffer word's low 9 bits take the data masked to the mode's width, right-aligned. The unused upper data bits read 0. The data width comes from the mode-code table above.
- R2: In an asynchronous mode, the framing flag (bit 13) sets on transfer if stop bit 0 (`chr_stop[0]`) is low. When `two_stop`=1, it also sets if stop bit 1 (`chr_stop[1]`) is low. With one stop bit, `chr_stop[1]` is ignored.
- R3: In an asynchronous mode, the parity flag (bit 14) sets on transfer when the count of 1s across the masked data and `chr_par` is odd with `par_odd`=0, or even with `par_odd`=1.
- R4: The overrun flag (bit 12) sets on a transfer in an asynchronous mode when the previous character was transferred and has not been acknowledged by a low-byte read.
- R5: The summary flag (bit 15) is 1 exactly when at least one of bits 12, 13 and 14 is 1.
- R6: A low-byte read (`rd_lo`=1) with no character strobe in the same cycle clears bits 12 to 15 on the next clock and leaves the data bits unchanged.
- R7: A cycle with `rx_en`=0 or `mode`=000 clears bits 12 to 15 on the next clock. The data bits are left unchanged.
- R8: In any mode with `mode[2]`=0, bits 12 to 15 read 0 at once, including after a character with bad stop or parity bits.
- R9: When a read strobe and a character strobe occur in the same cycle, the new character's framing and parity results are stored. No overrun is flagged, because the previous character counts as read.
- R10: After reset, the buffer word is 0. Bits 9 to 11 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Serial mode code |
| rx_en | input | 1 | Receive enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits expected |
| chr_vld | input | 1 | One-cycle strobe: character complete |
| chr_data | input | 9 | Deserialized data bits, LSB first bit received |
| chr_par | input | 1 | Sampled parity bit |
| chr_stop | input | 2 | Sampled stop bits, bit 0 first |
| rd_lo | input | 1 | Host read strobe for the buffer low byte |
| rbuf | output | 16 | Buffer word: data[8:0], bit 12 overrun, 13 framing, 14 parity, 15 summary |

## Verification
The assertions assume the following about the inputs:
- `chr_vld` is a single-cycle pulse per character.
- The companion stop, parity and data inputs are valid in that cycle.
- `mode` and `rx_en` change only between clock edges, never at an edge.

The stimulus drives all inputs on the falling edge and holds each strobe for exactly one cycle. It changes the mode only while no character is pending in that cycle. This keeps every flag property in the stable-configuration case that it describes.

// File: rtl/uart_rx_errbuf.sv
module uart_rx_errbuf (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  mode,
  input  logic        rx_en,
  input  logic        par_odd,
  input  logic        two_stop,
  input  logic        chr_vld,
  input  logic [8:0]  chr_data,
  input  logic        chr_par,
  input  logic [1:0]  chr_stop,
  input  logic        rd_lo,
  output logic [15:0] rbuf
);

  localparam logic [2:0] MODE_OFF = 3'b000;

  logic [8:0] dmask, data_in, data_q;
  logic       fer_q, per_q, oer_q, full_q;
  logic       async_m, off, par_bad, stop_bad, sum;

  assign async_m = mode[2];
  assign off     = (mode == MODE_OFF) || !rx_en;

  always_comb begin
    case (mode[1:0])
      2'b00:   dmask = 9'h07F;
      2'b10:   dmask = 9'h1FF;
      default: dmask = 9'h0FF;
    endcase
  end

  assign data_in  = chr_data & dmask;
  assign par_bad  = (^data_in) ^ chr_par ^ par_odd;
  assign stop_bad = !chr_stop[0] || (two_stop && !chr_stop[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      fer_q  <= 1'b0;
      per_q  <= 1'b0;
      oer_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (off) begin
      fer_q  <= 1'b0;
      per_q  <= 1'b0;
      oer_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (chr_vld) begin
      data_q <= data_in;
      full_q <= 1'b1;
      fer_q  <= async_m && stop_bad;
      per_q  <= async_m && par_bad;
      oer_q  <= async_m && full_q && !rd_lo;
    end else begin
      if (rd_lo) full_q <= 1'b0;
      if (rd_lo || !async_m) begin
        fer_q <= 1'b0;
        per_q <= 1'b0;
        oer_q <= 1'b0;
      end
    end
  end

  assign sum  = fer_q || per_q || oer_q;
  assign rbuf = {async_m & sum, async_m & per_q, async_m & fer_q, async_m & oer_q,
                 3'b000, data_q};

  a_r7_clear_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (!fer_q && !per_q && !oer_q));

  a_r2_framing_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!off && async_m && chr_vld && !chr_stop[0]) |=> fer_q);

  a_r4_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!off && async_m && chr_vld && full_q && !rd_lo) |=> oer_q);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!off && rd_lo && !chr_vld) |=> (!fer_q && !per_q && !oer_q));

  a_r9_new_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!off && async_m && chr_vld && rd_lo && !chr_stop[0]) |=> (fer_q && !oer_q));

  a_r1_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!chr_vld) |=> $stable(data_q));

endmodule

// File: tb/uart_rx_errbuf_tb.sv
module uart_rx_errbuf_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'b101;
  logic        rx_en = 1'b1;
  logic        par_odd = 1'b0;
  logic        two_stop = 1'b0;
  logic        chr_vld = 1'b0;
  logic [8:0]  chr_data = '0;
  logic        chr_par = 1'b0;
  logic [1:0]  chr_stop = 2'b01;
  logic        rd_lo = 1'b0;
  logic [15:0] rbuf;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  uart_rx_errbuf u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_en(rx_en), .par_odd(par_odd),
    .two_stop(two_stop), .chr_vld(chr_vld), .chr_data(chr_data), .chr_par(chr_par),
    .chr_stop(chr_stop), .rd_lo(rd_lo), .rbuf(rbuf)
  );

  // {mode, par_odd, two_stop, data, par, stop, expected}
  localparam int NV = 14;
  localparam logic [32:0] VEC [NV] = '{
    {3'b101, 1'b0, 1'b0, 9'h0A5, 1'b0, 2'b01, 16'h00A5},  // R1 R3 even ok
    {3'b101, 1'b0, 1'b0, 9'h0A5, 1'b1, 2'b01, 16'hC0A5},  // R3 even bad
    {3'b101, 1'b1, 1'b0, 9'h0A5, 1'b1, 2'b01, 16'h00A5},  // R3 odd ok
    {3'b101, 1'b1, 1'b0, 9'h0FF, 1'b0, 2'b01, 16'hC0FF},  // R3 odd bad
    {3'b100, 1'b0, 1'b0, 9'h1FF, 1'b1, 2'b01, 16'h007F},  // R1 7-bit mask
    {3'b110, 1'b0, 1'b0, 9'h1FF, 1'b1, 2'b01, 16'h01FF},  // R1 9-bit
    {3'b110, 1'b0, 1'b0, 9'h100, 1'b0, 2'b01, 16'hC100},  // R3 9-bit bad
    {3'b101, 1'b0, 1'b0, 9'h003, 1'b0, 2'b00, 16'hA003},  // R2 one stop low
    {3'b101, 1'b0, 1'b1, 9'h003, 1'b0, 2'b01, 16'hA003},  // R2 second stop low
    {3'b101, 1'b0, 1'b1, 9'h003, 1'b0, 2'b11, 16'h0003},  // R2 two stops ok
    {3'b101, 1'b0, 1'b0, 9'h003, 1'b0, 2'b10, 16'hA003},  // R2 first stop low
    {3'b101, 1'b0, 1'b0, 9'h003, 1'b0, 2'b01, 16'h0003},  // R2 second ignored
    {3'b001, 1'b0, 1'b0, 9'h055, 1'b1, 2'b00, 16'h0055},  // R8 sync gated
    {3'b010, 1'b0, 1'b0, 9'h1AA, 1'b0, 2'b00, 16'h01AA}   // R8 bus gated
  };

  task automatic check(input string req, input logic [15:0] exp);
    n_chk++;
    if (rbuf !== exp) begin
      n_bad++;
      $display("FAIL %s: rbuf=%h expected=%h", req, rbuf, exp);
    end
  endtask

  task automatic xfer(input logic [8:0] d, input logic p, input logic [1:0] s, input logic rd);
    @(negedge clk);
    chr_vld = 1'b1; chr_data = d; chr_par = p; chr_stop = s; rd_lo = rd;
    @(negedge clk);
    chr_vld = 1'b0; rd_lo = 1'b0;
  endtask

  task automatic read_lo();
    @(negedge clk);
    rd_lo = 1'b1;
    @(negedge clk);
    rd_lo = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: rbuf=%h expected=done", rbuf);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      read_lo();
      mode = VEC[i][32:30]; par_odd = VEC[i][29]; two_stop = VEC[i][28];
      xfer(VEC[i][27:19], VEC[i][18], VEC[i][17:16], 1'b0);
      check("R1/R2/R3/R8 vector", VEC[i][15:0]);
    end

    mode = 3'b101; par_odd = 1'b0; two_stop = 1'b0;
    read_lo();
    xfer(9'h011, 1'b0, 2'b01, 1'b0);
    check("R1 clean", 16'h0011);
    xfer(9'h003, 1'b0, 2'b01, 1'b0);
    check("R4 R5 overrun", 16'h9003);
    read_lo();
    check("R6 read clears", 16'h0003);

    xfer(9'h003, 1'b0, 2'b01, 1'b0);
    xfer(9'h003, 1'b0, 2'b00, 1'b1);
    check("R9 read with transfer", 16'hA003);

    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    check("R7 rx disable clears", 16'h0003);

    read_lo();
    xfer(9'h003, 1'b1, 2'b01, 1'b0);
    check("R3 R5 parity latched", 16'hC003);
    @(negedge clk); mode = 3'b000;
    @(negedge clk); mode = 3'b101;
    #1;
    check("R7 mode off clears", 16'h0003);

    read_lo();
    xfer(9'h003, 1'b0, 2'b00, 1'b0);
    check("R2 framing latched", 16'hA003);
    mode = 3'b001;
    #1;
    check("R8 gated at once", 16'h0003);
    mode = 3'b101;
    #1;
    check("R10 bits 9-11 zero", rbuf & 16'h0E00 | 16'hA003);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule